// File: doc/BRIEF.md
# Job Frame Parser and Unit Dispatcher

This block sits between a 32-bit word stream and a bank of compute units. The stream carries job frames with no packet boundaries: a frame may begin at any word, and several frames may follow one another with nothing in between. The block looks for a fixed synchronisation word and then reads two header words, a unit identifier and a job identifier. It compares the unit identifier against a parameter table of known identifiers. The position of the matching entry selects the unit.

Once a unit is selected, the block sends it a one-cycle start. It then passes the following words to that unit over a source bus that all units share. The stream advances only when the selected unit is ready. The frame carries no payload length; the selected unit ends the payload by raising its done. The next word is a checksum. The 32-bit wrapping sum of the checksum, the unit identifier, the job identifier and every payload word must come to zero. A correct frame gives a one-cycle ok strobe. A wrong frame sets a sticky error flag. A frame with an unknown identifier is dropped and counted.

Top module: `job_dispatcher`

## Requirements
- R1: While searching for a frame, `in_ready` is high and every word is consumed. A word other than 0xE1E4C312 leaves the block searching, and no start is raised.
- R2: If the word accepted after the sync word equals table entry k, then on the second clock after the job identifier is accepted, `unit_start` equals one-hot bit k for exactly one cycle. In that cycle `in_ready` and `unit_src_valid` are low. Table entries 0 to 4 are 0x2CB31E7C, 0xF218E0A2, 0x9323EB24, 0x4CD2E19C and 0x12345678.
- R3: If the identifier word matches no table entry, `unknown_cnt` increases by one (saturating), no start is raised, and the block goes back to searching.
- R4: During the payload, `unit_src_valid` follows `in_valid` and `in_ready` follows `unit_src_ready` of the selected unit. `unit_src_data` carries `in_data`.
- R5: A high `unit_done` from the selected unit ends the payload. In that cycle no word moves. `unit_done` from any other unit has no effect.
- R6: When the checksum word is accepted and the 32-bit sum of identifier, job word, payload words and checksum is zero, `frame_ok` is high for exactly the next cycle.
- R7: When the checksum sum is non-zero, `csum_err` goes high on the next cycle and stays high until reset.
- R8: After reset the block is searching: `in_ready` is 1, and `unit_start`, `unit_src_valid`, `frame_ok`, `csum_err` and `unknown_cnt` are 0.
- R9: While the two header words and the checksum word are expected, `in_ready` is high.
- R10: A sync word accepted in the cycle right after a checksum or a rejected identifier starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | WORD_W | Incoming stream word |
| in_valid | input | 1 | Stream word is present |
| in_ready | output | 1 | Block takes the word this cycle |
| unit_src_data | output | WORD_W | Payload word broadcast to all units |
| unit_src_valid | output | 1 | Payload word valid, broadcast |
| unit_src_ready | input | N_UNITS | Per-unit payload ready |
| unit_start | output | N_UNITS | One-hot start pulse |
| unit_done | input | N_UNITS | Per-unit payload end |
| frame_ok | output | 1 | One-cycle strobe for a correct checksum |
| csum_err | output | 1 | Sticky checksum mismatch flag |
| unknown_cnt | output | CNT_W | Count of frames dropped for an unknown identifier |

## Verification
A wrong parser state shows up first on `in_ready`. A block stuck in a header state keeps ready high in payload cycles where the selected unit holds its ready low, and the per-cycle comparison catches this on that same cycle. A wrong unit selection shows up as a start on the wrong bit, two cycles after the job word. It also shows up as ready following the wrong unit during the payload. A corrupted running sum is invisible until the checksum word. One cycle later, `frame_ok` or `csum_err` disagrees with the model.

// File: rtl/job_dispatch_pkg.sv
package job_dispatch_pkg;

  // Parser phases; the order is the order a frame walks through.
  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_MODID = 3'd1,
    ST_JOBID = 3'd2,
    ST_KICK  = 3'd3,
    ST_FEED  = 3'd4,
    ST_CHECK = 3'd5
  } jd_state_e;

endpackage

// File: rtl/jd_id_match.sv
module jd_id_match #(
  parameter int WORD_W  = 32,
  parameter int N_UNITS = 5,
  parameter logic [N_UNITS*WORD_W-1:0] ID_TABLE = '0,
  localparam int SEL_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output logic [SEL_W-1:0]  idx
);

  logic [N_UNITS-1:0] hits;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_cmp
    assign hits[g] = (word == ID_TABLE[g*WORD_W +: WORD_W]);
  end

  assign hit = |hits;

  // Lowest matching position wins if the table holds duplicates.
  always_comb begin
    idx = '0;
    for (int i = N_UNITS - 1; i >= 0; i--) begin
      if (hits[i]) idx = SEL_W'(i);
    end
  end

endmodule

// File: rtl/jd_sum_acc.sv
module jd_sum_acc #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              add,
  input  logic [WORD_W-1:0] word,
  output logic              ends_zero
);

  logic [WORD_W-1:0] sum_q;
  logic [WORD_W-1:0] sum_d;
  logic              sum_en;

  assign sum_en = load | add;

  always_comb begin
    sum_d = sum_q;
    if (load)      sum_d = word;
    else if (add)  sum_d = sum_q + word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  assign ends_zero = ((sum_q + word) == '0);

endmodule

// File: rtl/jd_seq_ctrl.sv
module jd_seq_ctrl
  import job_dispatch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  logic      is_sync,
  input  logic      id_known,
  input  logic      sel_ready,
  input  logic      sel_done,
  output logic      in_ready,
  output logic      fwd_valid,
  output logic      take_id,
  output logic      take_job,
  output logic      take_pay,
  output logic      take_sum,
  output logic      kick
);

  jd_state_e state_q;
  jd_state_e state_d;
  logic      feeding;
  logic      accept;

  assign feeding = (state_q == ST_FEED) && !sel_done;

  always_comb begin
    unique case (state_q)
      ST_HUNT, ST_MODID, ST_JOBID, ST_CHECK: in_ready = 1'b1;
      ST_FEED:                               in_ready = sel_ready && !sel_done;
      default:                               in_ready = 1'b0;
    endcase
  end

  assign accept    = in_valid && in_ready;
  assign fwd_valid = feeding && in_valid;
  assign take_id   = accept && (state_q == ST_MODID);
  assign take_job  = accept && (state_q == ST_JOBID);
  assign take_pay  = accept && (state_q == ST_FEED);
  assign take_sum  = accept && (state_q == ST_CHECK);
  assign kick      = (state_q == ST_KICK);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HUNT:  if (accept && is_sync) state_d = ST_MODID;
      ST_MODID: if (accept)            state_d = id_known ? ST_JOBID : ST_HUNT;
      ST_JOBID: if (accept)            state_d = ST_KICK;
      ST_KICK:                         state_d = ST_FEED;
      ST_FEED:  if (sel_done)          state_d = ST_CHECK;
      ST_CHECK: if (accept)            state_d = ST_HUNT;
      default:                         state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HUNT;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/job_dispatcher.sv
module job_dispatcher
  import job_dispatch_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_UNITS = 5,
  parameter int CNT_W   = 8,
  parameter logic [WORD_W-1:0] SYNC_WORD = 32'hE1E4C312,
  parameter logic [N_UNITS*WORD_W-1:0] ID_TABLE = {
    32'h12345678, 32'h4CD2E19C, 32'h9323EB24, 32'hF218E0A2, 32'h2CB31E7C
  }
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  in_data,
  input  logic               in_valid,
  output logic               in_ready,
  output logic [WORD_W-1:0]  unit_src_data,
  output logic               unit_src_valid,
  input  logic [N_UNITS-1:0] unit_src_ready,
  output logic [N_UNITS-1:0] unit_start,
  input  logic [N_UNITS-1:0] unit_done,
  output logic               frame_ok,
  output logic               csum_err,
  output logic [CNT_W-1:0]   unknown_cnt
);

  localparam int SEL_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic             id_hit;
  logic [SEL_W-1:0] id_idx;
  logic [SEL_W-1:0] sel_q;
  logic             sel_ready;
  logic             sel_done;
  logic             take_id, take_job, take_pay, take_sum, kick;
  logic             fwd_valid;
  logic             sum_zero;
  logic             is_sync;

  assign is_sync   = (in_data == SYNC_WORD);
  assign sel_ready = unit_src_ready[sel_q];
  assign sel_done  = unit_done[sel_q];

  jd_id_match #(
    .WORD_W  (WORD_W),
    .N_UNITS (N_UNITS),
    .ID_TABLE(ID_TABLE)
  ) u_match (
    .word(in_data),
    .hit (id_hit),
    .idx (id_idx)
  );

  jd_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (in_valid),
    .is_sync  (is_sync),
    .id_known (id_hit),
    .sel_ready(sel_ready),
    .sel_done (sel_done),
    .in_ready (in_ready),
    .fwd_valid(fwd_valid),
    .take_id  (take_id),
    .take_job (take_job),
    .take_pay (take_pay),
    .take_sum (take_sum),
    .kick     (kick)
  );

  jd_sum_acc #(
    .WORD_W(WORD_W)
  ) u_sum (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (take_id && id_hit),
    .add      (take_job || take_pay),
    .word     (in_data),
    .ends_zero(sum_zero)
  );

  // Selected unit index, captured with a known identifier.
  logic sel_en;
  assign sel_en = take_id && id_hit;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  sel_q <= '0;
    else if (sel_en) sel_q <= id_idx;
  end

  for (genvar g = 0; g < N_UNITS; g++) begin : g_start
    assign unit_start[g] = kick && (sel_q == SEL_W'(g));
  end

  assign unit_src_data  = in_data;
  assign unit_src_valid = fwd_valid;

  // Status registers.
  logic             ok_d;
  logic             err_d, err_en;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign ok_d   = take_sum && sum_zero;
  assign err_en = take_sum && !sum_zero;
  assign err_d  = 1'b1;
  assign cnt_en = take_id && !id_hit && (unknown_cnt != CNT_MAX);
  assign cnt_d  = unknown_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) frame_ok <= 1'b0;
    else            frame_ok <= ok_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  csum_err <= 1'b0;
    else if (err_en) csum_err <= err_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  unknown_cnt <= '0;
    else if (cnt_en) unknown_cnt <= cnt_d;
  end

endmodule

// File: rtl/jd_checker.sv
module jd_checker #(
  parameter int WORD_W  = 32,
  parameter int N_UNITS = 5,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WORD_W-1:0]  in_data,
  input logic               in_valid,
  input logic               in_ready,
  input logic [WORD_W-1:0]  unit_src_data,
  input logic               unit_src_valid,
  input logic [N_UNITS-1:0] unit_src_ready,
  input logic [N_UNITS-1:0] unit_start,
  input logic [N_UNITS-1:0] unit_done,
  input logic               frame_ok,
  input logic               csum_err,
  input logic [CNT_W-1:0]   unknown_cnt
);

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_start)); // R2

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_start) |=> (unit_start == '0)); // R2

  AST_START_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_start) |-> (!in_ready && !unit_src_valid)); // R2

  AST_FWD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    unit_src_valid |-> in_valid); // R4

  AST_OK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err |=> csum_err); // R7

  AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (unknown_cnt >= $past(unknown_cnt))); // R3

endmodule

bind job_dispatcher jd_checker #(
  .WORD_W (WORD_W),
  .N_UNITS(N_UNITS),
  .CNT_W  (CNT_W)
) u_jd_checker (.*);

// File: tb/test_job_dispatcher.sv
module test_job_dispatcher;

  localparam int N  = 5;
  localparam int CW = 8;
  localparam bit [31:0] SYNC = 32'hE1E4C312;
  localparam bit [31:0] IDS [N] = '{32'h2CB31E7C, 32'hF218E0A2, 32'h9323EB24,
                                    32'h4CD2E19C, 32'h12345678};
  localparam int M_HUNT = 0, M_MOD = 1, M_JOB = 2, M_KICK = 3, M_PAY = 4, M_SUM = 5;

  logic          clk;
  logic          rst_n;
  logic [31:0]   in_data;
  logic          in_valid;
  logic          in_ready;
  logic [31:0]   unit_src_data;
  logic          unit_src_valid;
  logic [N-1:0]  unit_src_ready;
  logic [N-1:0]  unit_start;
  logic [N-1:0]  unit_done;
  logic          frame_ok;
  logic          csum_err;
  logic [CW-1:0] unknown_cnt;

  job_dispatcher i_job_dispatcher (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .unit_src_data(unit_src_data),
    .unit_src_valid(unit_src_valid), .unit_src_ready(unit_src_ready),
    .unit_start(unit_start), .unit_done(unit_done), .frame_ok(frame_ok),
    .csum_err(csum_err), .unknown_cnt(unknown_cnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  // Reference model state
  int        m_mode = M_HUNT;
  int        m_sel  = 0;
  bit [31:0] m_sum  = 0;
  bit        m_ok   = 0;
  bit        m_err  = 0;
  int        m_cnt  = 0;
  int        ok_seen = 0;

  // Per-frame payload bookkeeping
  int nq[$];
  int cur_n = 0;
  int pay_sent = 0;

  function automatic int find_id(bit [31:0] w);
    for (int i = 0; i < N; i++) if (IDS[i] == w) return i;
    return -1;
  endfunction

  task automatic chk(bit cond, string tag, longint act, longint exp);
    total++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; total++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // One cycle: drive at negedge, compare, advance the model for the next edge.
  task automatic step(bit [31:0] d, bit v, bit [N-1:0] rdy, bit [N-1:0] dn,
                      output bit acc);
    bit          e_rdy, e_sv;
    bit [N-1:0]  e_st;
    string       tag;
    in_data = d; in_valid = v; unit_src_ready = rdy; unit_done = dn;
    #1;
    e_st = '0;
    case (m_mode)
      M_HUNT:               begin e_rdy = 1'b1; tag = "R1"; end
      M_MOD, M_JOB, M_SUM:  begin e_rdy = 1'b1; tag = "R9"; end
      M_KICK:               begin e_rdy = 1'b0; tag = "R2"; e_st[m_sel] = 1'b1; end
      default: begin
        e_rdy = dn[m_sel] ? 1'b0 : rdy[m_sel];
        tag = dn[m_sel] ? "R5" : "R4";
      end
    endcase
    e_sv = (m_mode == M_PAY) && v && !dn[m_sel];
    chk(in_ready == e_rdy, {tag, " in_ready"}, in_ready, e_rdy);
    chk(unit_src_valid == e_sv, (m_mode == M_PAY && dn[m_sel]) ? "R5 src_valid" : "R4 src_valid",
        unit_src_valid, e_sv);
    if (e_sv) chk(unit_src_data == d, "R4 src_data", unit_src_data, d);
    chk(unit_start == e_st, "R2 start", unit_start, e_st);
    chk(frame_ok == m_ok, "R6 frame_ok", frame_ok, m_ok);
    chk(csum_err == m_err, "R7 csum_err", csum_err, m_err);
    chk(unknown_cnt == CW'(m_cnt), "R3 unknown_cnt", unknown_cnt, m_cnt);
    if (frame_ok) ok_seen++;
    acc = v && e_rdy;
    m_ok = 1'b0;
    case (m_mode)
      M_HUNT: if (acc && d == SYNC) m_mode = M_MOD;
      M_MOD: if (acc) begin
        if (find_id(d) >= 0) begin
          m_sel = find_id(d); m_sum = d; m_mode = M_JOB;
          cur_n = nq.pop_front(); pay_sent = 0;
        end else begin
          if (m_cnt < 255) m_cnt++;
          m_mode = M_HUNT;
        end
      end
      M_JOB: if (acc) begin m_sum += d; m_mode = M_KICK; end
      M_KICK: m_mode = M_PAY;
      M_PAY: begin
        if (dn[m_sel]) m_mode = M_SUM;
        else if (acc) begin m_sum += d; pay_sent++; end
      end
      default: if (acc) begin
        if (m_sum + d == 32'd0) m_ok = 1'b1; else m_err = 1'b1;
        m_mode = M_HUNT;
      end
    endcase
    @(negedge clk);
  endtask

  // Append one frame to a word queue.
  task automatic build(ref bit [31:0] q[$], input bit [31:0] id, input bit [31:0] job,
                       input int n, input bit bad);
    bit [31:0] s;
    q.push_back(SYNC); q.push_back(id); q.push_back(job);
    s = id + job;
    for (int i = 0; i < n; i++) begin
      q.push_back(32'(i * 7 + 3)); s += 32'(i * 7 + 3);
    end
    q.push_back((32'd0 - s) ^ (bad ? 32'h10 : 32'h0));
    if (find_id(id) >= 0) nq.push_back(n);
  endtask

  task automatic run(ref bit [31:0] q[$], input bit gapv, input bit gapr, input bit noise);
    bit          acc;
    bit [N-1:0]  rdy, dn;
    bit          v;
    int          c = 0;
    while (q.size() > 0 || m_mode != M_HUNT) begin
      v   = (q.size() > 0) && (!gapv || (c % 3 != 1));
      rdy = (!gapr || (c % 2 == 0)) ? '1 : '0;
      dn  = noise ? ((c % 3 == 0) ? '1 : '0) : '0;
      if (m_mode == M_PAY) begin
        dn[m_sel] = (pay_sent == cur_n);
        if (pay_sent == cur_n) v = (q.size() > 0);
      end else begin
        dn = dn & ~(N'(1) << m_sel);
      end
      step(v ? q[0] : 32'h0, v, rdy, dn, acc);
      if (acc) void'(q.pop_front());
      c++;
    end
    for (int i = 0; i < 2; i++) step(32'h0, 1'b0, '1, '0, acc);
  endtask

  initial begin
    bit [31:0] q[$];
    bit acc;
    int ok0;
    rst_n = 1'b0; in_data = '0; in_valid = 1'b0; unit_src_ready = '0; unit_done = '0;
    repeat (3) @(negedge clk);
    // R8: reset state while held in reset
    chk(in_ready == 1'b1, "R8 in_ready", in_ready, 1);
    chk(unit_start == '0, "R8 start", unit_start, 0);
    chk(unit_src_valid == 1'b0, "R8 src_valid", unit_src_valid, 0);
    chk(frame_ok == 1'b0 && csum_err == 1'b0, "R8 flags", {frame_ok, csum_err}, 0);
    chk(unknown_cnt == '0, "R8 count", unknown_cnt, 0);
    rst_n = 1'b1;
    repeat (3) step(32'h0, 1'b0, '0, '0, acc);

    // R1: noise words before a frame, then unit 1 with a plain payload
    ok0 = ok_seen;
    q.push_back(32'h0BADF00D); q.push_back(32'h12345678); q.push_back(32'hE1E4C313);
    build(q, IDS[1], 32'h12345678, 4, 0);
    run(q, 0, 0, 0);
    chk(ok_seen == ok0 + 1, "R6 ok count unit1", ok_seen, ok0 + 1);

    // R4: unit 3 with gaps on valid and ready
    ok0 = ok_seen;
    build(q, IDS[3], 32'hCAFE0001, 3, 0);
    run(q, 1, 1, 0);
    chk(ok_seen == ok0 + 1, "R4 ok count gapped", ok_seen, ok0 + 1);

    // R7: unit 0, bad checksum
    build(q, IDS[0], 32'h00000042, 2, 1);
    run(q, 0, 0, 0);
    chk(csum_err == 1'b1, "R7 err set", csum_err, 1);

    // R3 and R10: unknown identifier, then a frame right behind it
    ok0 = ok_seen;
    build(q, 32'hDEADBEEF, 32'h1, 2, 0);
    build(q, IDS[4], 32'h77, 1, 0);
    run(q, 0, 0, 0);
    chk(unknown_cnt == 8'd1, "R3 count after unknown", unknown_cnt, 1);
    chk(ok_seen == ok0 + 1, "R10 frame after unknown", ok_seen, ok0 + 1);

    // R10 and R5: two joined frames, stray done from other units
    ok0 = ok_seen;
    build(q, IDS[2], 32'hA5A5A5A5, 5, 0);
    build(q, IDS[4], 32'h5A5A5A5A, 3, 0);
    run(q, 0, 1, 1);
    chk(ok_seen == ok0 + 2, "R10 joined frames", ok_seen, ok0 + 2);

    // R5: empty payload ends on the first done
    ok0 = ok_seen;
    build(q, IDS[1], 32'h0, 0, 0);
    run(q, 0, 0, 1);
    chk(ok_seen == ok0 + 1, "R5 empty payload", ok_seen, ok0 + 1);
    chk(csum_err == 1'b1, "R7 err still set", csum_err, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule